// File: doc/BRIEF.md
# Serial Word Transmitter with Reply Handshake

This block feeds a single serial line with 12-bit words, one bit per clock, toward a line encoder. Each word comes from one of three sources: a byte waiting at the head of the transmit FIFO, an acknowledge request raised by the local receiver, or a character waiting in a terminal register. The block picks one source, builds the word, and adds a start bit, two source-identification bits and an odd parity bit. It then shifts the word out, most significant bit first.

Data bytes use stop-and-wait. After a data word is loaded, no further FIFO byte is taken until the receiver reports that an acknowledge word came back from the far end. Terminal and acknowledge words do not wait and still go out during the wait. A counter bounds the wait. If no acknowledge arrives in time, the block pulses a timeout flag toward the bus side and sends a special acknowledge word to the far end. It does not resend the data byte.

Top module: `serial_word_tx`

## Requirements
- R1: Every word is 12 bits, driven on `ser_out` one bit per clock, MSB first, over 12 consecutive cycles with `ser_active` high. Those cycles start in the cycle after the take edge. The bit order is start bit (always 1), terminal-ID bit, parity bit, reply-ID bit, then data bits 7 down to 0. `ser_out` is 0 whenever `ser_active` is low.
- R2: The parity bit makes the total count of ones over the terminal-ID bit, the reply-ID bit, the parity bit and the 8 data bits odd.
- R3: A FIFO word carries the FIFO byte with both ID bits 0. `fifo_pop` is high for the single cycle whose rising edge takes the byte.
- R4: A terminal word carries `term_data` with the terminal-ID bit 1 and the reply-ID bit 0. `term_take` is high for the cycle of the take edge.
- R5: An acknowledge request sends data 0x00 with the reply-ID bit 1 and the terminal-ID bit 0. The value on `fifo_data` or `term_data` has no effect on it. `reply_take` is high for the cycle of the take edge.
- R6: A word is taken only while the line is idle, and only one source is taken at a time. The order of precedence is the pending timeout word, then the acknowledge request, then the terminal register, then the FIFO. At least one idle cycle separates two words.
- R7: `waiting` rises on the edge that takes a FIFO byte. While it is high, no FIFO byte is taken. It falls on the first edge that samples `rx_reply` high.
- R8: Terminal and acknowledge words are still sent while `waiting` is high, and sending them leaves `waiting` high.
- R9: Count the edge that takes a FIFO byte as edge 0. If `rx_reply` is not sampled high on any edge from 1 to TIMEOUT_WORDS*12, then edge TIMEOUT_WORDS*12 does three things: it drops `waiting`, it raises `timeout` for exactly one cycle, and it queues a special word (data 0xFF, reply-ID 1, wire value 0x9FF). The special word is sent ahead of every other source. A reply sampled on that last edge cancels the timeout.
- R10: `rx_reply` sampled while `waiting` is low has no effect, so the next FIFO byte still waits for its own reply.
- R11: During and right after reset, `ser_out`, `ser_active`, `waiting` and `timeout` are 0, and no take signal is high while no source is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one line bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_valid | input | 1 | Transmit FIFO holds a byte |
| fifo_data | input | 8 | Byte at the FIFO head |
| fifo_pop | output | 1 | FIFO byte taken on this edge |
| term_valid | input | 1 | Terminal character pending |
| term_data | input | 8 | Terminal character |
| term_take | output | 1 | Terminal character taken on this edge |
| reply_req | input | 1 | Local receiver asks for an acknowledge word |
| reply_take | output | 1 | Acknowledge request served on this edge |
| rx_reply | input | 1 | Acknowledge word from the far end was received |
| ser_out | output | 1 | Serial bit toward the line encoder |
| ser_active | output | 1 | A word is on the line |
| waiting | output | 1 | Waiting for the far-end acknowledge |
| timeout | output | 1 | One-cycle pulse: the acknowledge wait expired |

## Verification
The bench attacks three boundaries.

The first is the edge of the wait window. A reply arriving on the very last edge must cancel the timeout. If the compare were off by one, the block would either fire a false timeout and emit a stray 0x9FF word, or fire one cycle early.

The second is contention. All three sources are raised together. Wrong precedence would reorder the captured words, and a loose one-at-a-time rule would merge two takes into one load.

The third is the wait itself. FIFO bytes are held pending during a wait while terminal traffic is pushed through it. A design that let data slip past the handshake would pop the second byte early. A design that let terminal words block on the handshake would never take the character. A stray reply sent while idle checks that no acknowledge is latched for a later byte.

// File: rtl/swt_pkg.sv
package swt_pkg;
    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_DATA  = 2'd1,
        SRC_TERM  = 2'd2,
        SRC_REPLY = 2'd3
    } src_e;
endpackage

// File: rtl/swt_arbiter.sv
module swt_arbiter
    import swt_pkg::*;
(
    input  logic idle,
    input  logic special_pend,
    input  logic reply_req,
    input  logic term_valid,
    input  logic fifo_valid,
    input  logic waiting,
    output src_e sel,
    output logic special_sel
);
    always_comb begin
        sel         = SRC_NONE;
        special_sel = 1'b0;
        if (idle) begin
            if (special_pend) begin
                sel         = SRC_REPLY;
                special_sel = 1'b1;
            end else if (reply_req) begin
                sel = SRC_REPLY;
            end else if (term_valid) begin
                sel = SRC_TERM;
            end else if (fifo_valid && !waiting) begin
                sel = SRC_DATA;
            end
        end
    end
endmodule

// File: rtl/swt_word_build.sv
module swt_word_build
    import swt_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int WORD_W = DATA_W + 4
) (
    input  src_e              sel,
    input  logic              special,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [DATA_W-1:0] term_data,
    output logic [WORD_W-1:0] word
);
    logic              term_id;
    logic              reply_id;
    logic              parity;
    logic [DATA_W-1:0] payload;

    always_comb begin
        term_id  = (sel == SRC_TERM);
        reply_id = (sel == SRC_REPLY);
        case (sel)
            SRC_DATA:  payload = fifo_data;
            SRC_TERM:  payload = term_data;
            SRC_REPLY: payload = special ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
            default:   payload = {DATA_W{1'b0}};
        endcase
        parity = ~(^{term_id, reply_id, payload});
        word   = {1'b1, term_id, parity, reply_id, payload};
    end
endmodule

// File: rtl/swt_shifter.sv
module swt_shifter #(
    parameter int WORD_W = 12,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output logic              ser_out,
    output logic              active
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              busy;
    } shift_t;

    shift_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.sh   = word;
            st_d.cnt  = '0;
            st_d.busy = 1'b1;
        end else if (st_q.busy) begin
            if (st_q.cnt == CNT_W'(WORD_W - 1)) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.sh  = {st_q.sh[WORD_W-2:0], 1'b0};
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_out = st_q.busy & st_q.sh[WORD_W-1];
    assign active  = st_q.busy;

    // R1
    start_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ser_out);
    // R2
    odd_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> ($countones(st_q.sh[WORD_W-2:0]) % 2 == 1));
    // R6
    load_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !active);
endmodule

// File: rtl/swt_reply_timer.sv
module swt_reply_timer #(
    parameter int TO_CYC = 768,
    localparam int CNT_W = $clog2(TO_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rx_reply,
    input  logic special_taken,
    output logic waiting,
    output logic timeout,
    output logic special_pend
);
    typedef struct packed {
        logic             wt;
        logic [CNT_W-1:0] tmr;
        logic             to;
        logic             spec;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.to = 1'b0;
        if (special_taken) st_d.spec = 1'b0;
        if (start) begin
            st_d.wt  = 1'b1;
            st_d.tmr = '0;
        end else if (st_q.wt) begin
            if (rx_reply) begin
                st_d.wt = 1'b0;
            end else if (st_q.tmr == CNT_W'(TO_CYC - 1)) begin
                st_d.wt   = 1'b0;
                st_d.to   = 1'b1;
                st_d.spec = 1'b1;
            end else begin
                st_d.tmr = st_q.tmr + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign waiting      = st_q.wt;
    assign timeout      = st_q.to;
    assign special_pend = st_q.spec;

    // R7
    wait_rise_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(waiting) |-> $past(start));
    // R9
    timeout_ends_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> (!waiting && special_pend));
    // R9
    timeout_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
endmodule

// File: rtl/serial_word_tx.sv
module serial_word_tx
    import swt_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TIMEOUT_WORDS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              term_valid,
    input  logic [DATA_W-1:0] term_data,
    output logic              term_take,
    input  logic              reply_req,
    output logic              reply_take,
    input  logic              rx_reply,
    output logic              ser_out,
    output logic              ser_active,
    output logic              waiting,
    output logic              timeout
);
    localparam int WORD_W = DATA_W + 4;
    localparam int TO_CYC = TIMEOUT_WORDS * WORD_W;

    src_e              sel;
    logic              special_sel;
    logic              special_pend;
    logic [WORD_W-1:0] word;

    swt_arbiter u_arb (
        .idle        (!ser_active),
        .special_pend(special_pend),
        .reply_req   (reply_req),
        .term_valid  (term_valid),
        .fifo_valid  (fifo_valid),
        .waiting     (waiting),
        .sel         (sel),
        .special_sel (special_sel)
    );

    swt_word_build #(.DATA_W(DATA_W)) u_build (
        .sel      (sel),
        .special  (special_sel),
        .fifo_data(fifo_data),
        .term_data(term_data),
        .word     (word)
    );

    swt_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sel != SRC_NONE),
        .word   (word),
        .ser_out(ser_out),
        .active (ser_active)
    );

    swt_reply_timer #(.TO_CYC(TO_CYC)) u_tmr (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (fifo_pop),
        .rx_reply     (rx_reply),
        .special_taken(special_sel),
        .waiting      (waiting),
        .timeout      (timeout),
        .special_pend (special_pend)
    );

    assign fifo_pop   = (sel == SRC_DATA);
    assign term_take  = (sel == SRC_TERM) && !special_sel;
    assign reply_take = (sel == SRC_REPLY) && !special_sel;

    // R6
    one_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_pop, term_take, reply_take, special_sel}));
    // R6
    take_starts_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop || term_take || reply_take) |=> ser_active);
    // R7
    no_pop_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        waiting |-> !fifo_pop);
endmodule

// File: tb/sim_serial_word_tx.sv
module sim_serial_word_tx;
    localparam int CLK_PERIOD = 10;
    localparam int TO = 64 * 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fifo_valid = 1'b0, term_valid = 1'b0, reply_req = 1'b0, rx_reply = 1'b0;
    logic [7:0] fifo_data = 8'h00, term_data = 8'h00;
    logic fifo_pop, term_take, reply_take, ser_out, ser_active, waiting, timeout;

    int checks = 0, fails = 0, cyc = 0;
    logic [11:0] cap [0:63];
    int cap_n = 0, bit_n = 0;
    logic [11:0] sr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    serial_word_tx u0 (
        .clk(clk), .rst_n(rst_n),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .term_valid(term_valid), .term_data(term_data), .term_take(term_take),
        .reply_req(reply_req), .reply_take(reply_take), .rx_reply(rx_reply),
        .ser_out(ser_out), .ser_active(ser_active), .waiting(waiting), .timeout(timeout)
    );

    // word capture from the line
    always @(negedge clk) begin
        if (ser_active) begin
            sr = {sr[10:0], ser_out};
            bit_n++;
            if (bit_n == 12) begin
                if (cap_n < 64) cap[cap_n] = sr;
                cap_n++;
                bit_n = 0;
            end
        end else begin
            bit_n = 0;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            checks++; fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic took(input int k);
        return (k == 0) ? fifo_pop : (k == 1) ? term_take : reply_take;
    endfunction

    task automatic send(input int kind, input logic [7:0] b);
        @(negedge clk);
        case (kind)
            0: begin fifo_data = b; fifo_valid = 1'b1; end
            1: begin term_data = b; term_valid = 1'b1; end
            default: reply_req = 1'b1;
        endcase
        #1;
        while (!took(kind)) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        case (kind)
            0: fifo_valid = 1'b0;
            1: term_valid = 1'b0;
            default: reply_req = 1'b0;
        endcase
    endtask

    task automatic wait_words(input int n);
        while (cap_n < n) begin @(negedge clk); #2; end
    endtask

    task automatic pulse_reply();
        @(negedge clk); rx_reply = 1'b1;
        @(negedge clk); rx_reply = 1'b0; #1;
    endtask

    // kind(0 data,1 term,2 reply), byte, expected line word
    localparam logic [21:0] VEC [8] = '{
        {2'd0, 8'hA5, 12'hAA5},
        {2'd0, 8'h01, 12'h801},
        {2'd1, 8'h41, 12'hC41},
        {2'd1, 8'h7F, 12'hE7F},
        {2'd2, 8'h5A, 12'h900},
        {2'd0, 8'hFF, 12'hAFF},
        {2'd0, 8'h00, 12'hA00},
        {2'd1, 8'h00, 12'hC00}
    };

    initial begin
        int n0;
        int n;
        int pops;
        logic seen;
        int order [3];

        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!ser_out && !ser_active && !waiting && !timeout, "R11 outputs in reset", {ser_out, ser_active, waiting, timeout}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!ser_active && !waiting && !fifo_pop && !term_take && !reply_take, "R11 idle after reset",
            {ser_active, waiting, fifo_pop, term_take, reply_take}, 0);

        // R1 R2 R3 R4 R5 vector walk
        for (int i = 0; i < 8; i++) begin
            n0 = cap_n;
            send(int'(VEC[i][21:20]), VEC[i][19:12]);
            wait_words(n0 + 1);
            chk(cap[n0] == VEC[i][11:0], "R1/R2 word format (R3 R4 R5)", cap[n0], VEC[i][11:0]);
            if (VEC[i][21:20] == 2'd0) begin
                chk(waiting == 1'b1, "R7 waiting after data word", waiting, 1);
                pulse_reply();
                chk(waiting == 1'b0, "R7 reply ends wait", waiting, 0);
            end
        end

        // R6 precedence with all sources pending
        @(negedge clk);
        n0 = cap_n;
        reply_req = 1'b1; term_data = 8'h41; term_valid = 1'b1; fifo_data = 8'h01; fifo_valid = 1'b1;
        #1;
        for (int k = 0; k < 3; k++) begin
            while (!(fifo_pop | term_take | reply_take)) begin @(negedge clk); #1; end
            chk($countones({fifo_pop, term_take, reply_take}) == 1, "R6 single take", {fifo_pop, term_take, reply_take}, 1);
            order[k] = reply_take ? 2 : (term_take ? 1 : 0);
            @(posedge clk); #1;
            if (order[k] == 2) reply_req = 1'b0;
            else if (order[k] == 1) term_valid = 1'b0;
            else fifo_valid = 1'b0;
        end
        chk(order[0] == 2 && order[1] == 1 && order[2] == 0, "R6 take order", order[0]*16 + order[1]*4 + order[2], 2*16 + 4);
        wait_words(n0 + 3);
        chk(cap[n0] == 12'h900 && cap[n0+1] == 12'hC41 && cap[n0+2] == 12'h801, "R6 words in order", cap[n0+1], 12'hC41);
        pulse_reply();

        // R7 R8 stop-and-wait with terminal bypass
        n0 = cap_n;
        send(0, 8'h3C);
        @(negedge clk);
        fifo_data = 8'hC3; fifo_valid = 1'b1;
        pops = 0;
        for (int c = 0; c < 60; c++) begin @(negedge clk); #1; if (fifo_pop) pops++; end
        send(1, 8'h55);
        chk(waiting == 1'b1, "R8 terminal word leaves wait", waiting, 1);
        for (int c = 0; c < 100; c++) begin @(negedge clk); #1; if (fifo_pop) pops++; end
        chk(pops == 0, "R7 no pop while waiting", pops, 0);
        wait_words(n0 + 2);
        chk(cap[n0] == 12'hA3C && cap[n0+1] == 12'hC55, "R8 terminal sent during wait", cap[n0+1], 12'hC55);
        pulse_reply();
        seen = 1'b0;
        for (int c = 0; c < 30 && !seen; c++) begin #1; if (fifo_pop) seen = 1'b1; else @(negedge clk); end
        chk(seen, "R7 pop after reply", seen, 1);
        @(posedge clk); #1; fifo_valid = 1'b0;
        wait_words(n0 + 3);
        chk(cap[n0+2] == 12'hAC3, "R3 held byte sent", cap[n0+2], 12'hAC3);
        pulse_reply();

        // R9 timeout length and special word
        repeat (20) @(negedge clk);
        n0 = cap_n;
        fifo_data = 8'h12; fifo_valid = 1'b1; #1;
        while (!fifo_pop) begin @(negedge clk); #1; end
        @(posedge clk); #1; fifo_valid = 1'b0;
        n = 0;
        forever begin @(negedge clk); #1; if (timeout) break; n++; end
        chk(n == TO, "R9 timeout cycle count", n, TO);
        chk(!waiting, "R9 wait cleared on timeout", waiting, 0);
        @(negedge clk); #1;
        chk(!timeout, "R9 timeout is one cycle", timeout, 0);
        wait_words(n0 + 2);
        chk(cap[n0] == 12'hA12 && cap[n0+1] == 12'h9FF, "R9 special reply word", cap[n0+1], 12'h9FF);

        // R9 reply on last edge of the window cancels timeout
        repeat (5) @(negedge clk);
        n0 = cap_n;
        fifo_data = 8'h80; fifo_valid = 1'b1; #1;
        while (!fifo_pop) begin @(negedge clk); #1; end
        @(posedge clk); #1; fifo_valid = 1'b0;
        seen = 1'b0;
        for (int c = 0; c < TO; c++) begin @(negedge clk); #1; if (timeout) seen = 1'b1; end
        rx_reply = 1'b1;
        @(negedge clk); rx_reply = 1'b0; #1;
        if (timeout) seen = 1'b1;
        chk(!waiting, "R9 late reply accepted", waiting, 0);
        for (int c = 0; c < 60; c++) begin @(negedge clk); #1; if (timeout) seen = 1'b1; end
        chk(!seen, "R9 no timeout with last-edge reply", seen, 0);
        chk(cap_n == n0 + 1 && cap[n0] == 12'h880, "R9 no special word", cap_n - n0, 1);

        // R10 stray reply while idle
        pulse_reply();
        repeat (3) @(negedge clk);
        n0 = cap_n;
        send(0, 8'h00);
        repeat (50) @(negedge clk);
        #1;
        chk(waiting == 1'b1, "R10 stray reply ignored", waiting, 1);
        pulse_reply();
        wait_words(n0 + 1);
        chk(cap[n0] == 12'hA00 && !waiting, "R10 data word then reply", cap[n0], 12'hA00);

        summary();
        $finish;
    end
endmodule